// File: doc/BRIEF.md
# Program Sequencer with Skip Handling

This block is the fetch and control-flow unit of a single-issue core whose instruction word is 12 bits wide. It owns the 9-bit program counter and a small return stack. Each cycle it presents a fetch address. It receives the instruction fetched one cycle earlier from a memory with one cycle of latency. It then decides whether that instruction redirects the flow: by a jump, a subroutine call, a return that loads a literal into W, or a conditional skip whose outcome comes from the datapath. It also decodes the special control words: no-op, sleep, watchdog clear, option-register load and port-direction load.

A redirect or a taken skip makes the word that is already in flight useless. The sequencer then marks the next execution slot as a bubble by raising `nop_slot`. The datapath treats the word in that slot as a no-op. Branches and taken skips therefore take two cycles. Everything else takes one.

A three-state machine controls the slots. `ST_FILL` is the first slot after reset, when no valid word has arrived yet. `ST_RUN` executes the presented word. `ST_BUBBLE` discards it. The transitions are:
- `ST_FILL` to `ST_RUN`, always.
- `ST_RUN` to `ST_BUBBLE` on a jump, a call, a return or a taken skip.
- `ST_RUN` to `ST_RUN` for any other word.
- `ST_BUBBLE` to `ST_RUN`, always.

Top module: `prog_sequencer`

## Requirements
- R1: While reset is held, `pc` equals RESET_VEC, `nop_slot` is 1 and every strobe is 0. The first slot after reset is a bubble, and `pc` then advances by one each cycle.
- R2: A word matching 101t tttt tttt loads all nine target bits t into `pc`, including bit 8. The slot that follows is a bubble, so the jump takes two cycles.
- R3: A word matching 1001 kkkk kkkk pushes the address after the call onto the return stack. It loads `pc` with bit 8 cleared and bits 7:0 equal to k. The slot that follows is a bubble.
- R4: A word matching 1000 kkkk kkkk raises `w_we` with `w_data` equal to k. It loads `pc` from the top of the return stack with all nine bits restored. The slot that follows is a bubble.
- R5: The return stack holds STACK_DEPTH entries and shifts on push and pop. A push past full drops the oldest entry. A pop leaves a copy of the bottom entry in place, so further returns reach the oldest surviving address.
- R6: The skip words are 0010 11xx xxxx, 0011 11xx xxxx, 0110 xxxx xxxx and 0111 xxxx xxxx. When `skip_cond` is 1 during one of them, the next slot is a bubble and `pc` advances by one, for two cycles in total. When `skip_cond` is 0, the next word executes after one cycle.
- R7: `skip_cond` has no effect during any word that is not a skip word.
- R8: Word 0000 0000 0011 raises `sleep_stb` for one cycle. Word 0000 0000 0100 raises `wdt_clr_stb` for one cycle.
- R9: Word 0000 0000 0010 raises `opt_we` for one cycle, with `opt_data` equal to `w_in`.
- R10: Word 0000 0000 0110 raises `dir_we` for one cycle, with `dir_data` equal to `w_in`. A direction-load word with any other 3-bit field value writes nothing.
- R11: A word that arrives in a bubble slot does nothing. It raises no strobe and does not redirect `pc`.
- R12: Word 0000 0000 0000 raises no strobe and advances `pc` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 12 | Word fetched from the previous cycle's address |
| skip_cond | input | 1 | Datapath reports the skip condition holds for the current word |
| w_in | input | 8 | Current W register value |
| pc | output | 9 | Fetch address for this cycle |
| nop_slot | output | 1 | Current word must be treated as a no-op |
| sleep_stb | output | 1 | Enter standby |
| wdt_clr_stb | output | 1 | Clear the watchdog |
| opt_we | output | 1 | Write option register |
| opt_data | output | 8 | Value for the option register |
| dir_we | output | 1 | Write port direction latches |
| dir_data | output | 8 | Direction bits, 1 means high impedance |
| w_we | output | 1 | Load W with a literal from a return |
| w_data | output | 8 | Literal for W |

## Verification
The bench builds the block with its defaults: STACK_DEPTH of 2 and RESET_VEC of zero. With a two-entry stack, a three-deep call chain is enough to reach the overflow case. That chain shows the oldest return address being lost and the bottom entry being reused. A zero reset vector lets each program begin at address 0. The 9-bit counter still permits a jump above address 255, which exposes the difference between how jumps, calls and returns treat bit 8.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int INSN_W = 12;
    localparam int PC_W   = 9;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_RUN,
        ST_BUBBLE
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_OTHER,
        OP_NOP,
        OP_JUMP,
        OP_CALL,
        OP_RETLW,
        OP_SKIP,
        OP_SLEEP,
        OP_WDTCLR,
        OP_OPTLD,
        OP_DIRLD
    } op_class_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output op_class_e         op
);
    always_comb begin
        unique casez (instr)
            12'b101?_????_????: op = OP_JUMP;
            12'b1001_????_????: op = OP_CALL;
            12'b1000_????_????: op = OP_RETLW;
            12'b0010_11??_????: op = OP_SKIP;
            12'b0011_11??_????: op = OP_SKIP;
            12'b011?_????_????: op = OP_SKIP;
            12'b0000_0000_0000: op = OP_NOP;
            12'b0000_0000_0010: op = OP_OPTLD;
            12'b0000_0000_0011: op = OP_SLEEP;
            12'b0000_0000_0100: op = OP_WDTCLR;
            12'b0000_0000_0110: op = OP_DIRLD;
            default:            op = OP_OTHER;
        endcase
    end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int DEPTH = 2,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);
    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;

        if (i == 0) begin : g_first
            assign from_above = push_data;
        end else begin : g_inner
            assign from_above = ent[i-1];
        end

        if (i == DEPTH - 1) begin : g_last
            assign from_below = ent[i];
        end else begin : g_mid
            assign from_below = ent[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent[i] <= '0;
            else if (push)
                ent[i] <= from_above;
            else if (pop)
                ent[i] <= from_below;
        end
    end

    assign top = ent[0];
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int               STACK_DEPTH = 2,
    parameter logic [PC_W-1:0]  RESET_VEC   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] instr,
    input  logic              skip_cond,
    input  logic [DATA_W-1:0] w_in,
    output logic [PC_W-1:0]   pc,
    output logic              nop_slot,
    output logic              sleep_stb,
    output logic              wdt_clr_stb,
    output logic              opt_we,
    output logic [DATA_W-1:0] opt_data,
    output logic              dir_we,
    output logic [DATA_W-1:0] dir_data,
    output logic              w_we,
    output logic [DATA_W-1:0] w_data
);
    seq_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    op_class_e       op;
    logic            push, pop;
    logic [PC_W-1:0] ret_addr;

    seq_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    seq_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (PC_W)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (pc_q),
        .top       (ret_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            pc_q    <= RESET_VEC;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Transitions and next fetch address
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q + PC_W'(1);
        push    = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            ST_FILL:   state_d = ST_RUN;
            ST_BUBBLE: state_d = ST_RUN;
            ST_RUN: begin
                unique case (op)
                    OP_JUMP: begin
                        pc_d    = instr[PC_W-1:0];
                        state_d = ST_BUBBLE;
                    end
                    OP_CALL: begin
                        push    = 1'b1;
                        pc_d    = {1'b0, instr[DATA_W-1:0]};
                        state_d = ST_BUBBLE;
                    end
                    OP_RETLW: begin
                        pop     = 1'b1;
                        pc_d    = ret_addr;
                        state_d = ST_BUBBLE;
                    end
                    OP_SKIP: begin
                        if (skip_cond)
                            state_d = ST_BUBBLE;
                    end
                    default: ;
                endcase
            end
            default: state_d = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        logic run;
        run         = (state_q == ST_RUN);
        pc          = pc_q;
        nop_slot    = !run;
        sleep_stb   = run && (op == OP_SLEEP);
        wdt_clr_stb = run && (op == OP_WDTCLR);
        opt_we      = run && (op == OP_OPTLD);
        dir_we      = run && (op == OP_DIRLD);
        w_we        = run && (op == OP_RETLW);
        opt_data    = w_in;
        dir_data    = w_in;
        w_data      = instr[DATA_W-1:0];
    end
endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk
    import seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [INSN_W-1:0] instr,
    input logic              skip_cond,
    input logic [DATA_W-1:0] w_in,
    input logic [PC_W-1:0]   pc,
    input logic              nop_slot,
    input logic              sleep_stb,
    input logic              wdt_clr_stb,
    input logic              opt_we,
    input logic [DATA_W-1:0] opt_data,
    input logic              dir_we,
    input logic [DATA_W-1:0] dir_data,
    input logic              w_we,
    input logic [DATA_W-1:0] w_data
);
    logic is_skip;
    assign is_skip = (instr[11:6] == 6'b0010_11) || (instr[11:6] == 6'b0011_11)
                  || (instr[11:9] == 3'b011);

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot && instr[11:9] == 3'b101) |=> (nop_slot && pc == $past(instr[8:0]))); // R2

    AST_CALL_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot && instr[11:8] == 4'b1001) |=> (nop_slot && pc == {1'b0, $past(instr[7:0])})); // R3

    AST_RET_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot && instr[11:8] == 4'b1000) |-> (w_we && w_data == instr[7:0])); // R4

    AST_SKIP_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot && is_skip && skip_cond) |=> (nop_slot && pc == $past(pc) + 9'd1)); // R6

    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nop_slot |-> !(sleep_stb || wdt_clr_stb || opt_we || dir_we || w_we)); // R11

    AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        nop_slot |=> !nop_slot); // R11

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sleep_stb, wdt_clr_stb, opt_we, dir_we, w_we})); // R8

    AST_DIR_FROM_W: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |-> (dir_data == w_in && instr == 12'h006)); // R10

    AST_OPT_FROM_W: assert property (@(posedge clk) disable iff (!rst_n)
        opt_we |-> (opt_data == w_in && instr == 12'h002)); // R9
endmodule

bind prog_sequencer prog_sequencer_chk u_chk (.*);

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] instr = 12'h000;
    logic        skip_cond = 1'b0;
    logic [7:0]  w_in = 8'h00;
    logic [8:0]  pc;
    logic        nop_slot, sleep_stb, wdt_clr_stb, opt_we, dir_we, w_we;
    logic [7:0]  opt_data, dir_data, w_data;

    logic [11:0] rom [512];
    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [11:0] FILL_W = 12'hC00;

    prog_sequencer uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .skip_cond(skip_cond), .w_in(w_in),
        .pc(pc), .nop_slot(nop_slot), .sleep_stb(sleep_stb), .wdt_clr_stb(wdt_clr_stb),
        .opt_we(opt_we), .opt_data(opt_data), .dir_we(dir_we), .dir_data(dir_data),
        .w_we(w_we), .w_data(w_data)
    );

    always #4 clk = ~clk;

    // Program memory model with one cycle of read latency
    always @(posedge clk) instr <= rom[pc];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 512; i++) rom[i] = FILL_W;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic start(bit sc, logic [7:0] w);
        skip_cond = sc;
        w_in      = w;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [4:0] strobes();
        return {sleep_stb, wdt_clr_stb, opt_we, dir_we, w_we};
    endfunction

    task automatic t_reset();
        clear_rom();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset pc", pc, 0);
        chk("R1 reset bubble", nop_slot, 1);
        chk("R1 reset strobes", strobes(), 0);
        rst_n = 1'b1;
        step();
        chk("R1 first run pc", pc, 1);
        chk("R1 first run slot", nop_slot, 0);
        step();
        chk("R1 advance pc", pc, 2);
    endtask

    task automatic t_jump();
        clear_rom();
        rom[0] = 12'hA00 | 12'h150;
        start(1'b0, 8'h00);
        step(); chk("R2 exec pc", pc, 1);
        step(); chk("R2 target pc", pc, 9'h150); chk("R2 bubble", nop_slot, 1);
        step(); chk("R2 resume pc", pc, 9'h151); chk("R2 resume slot", nop_slot, 0);
    endtask

    task automatic t_call_nest();
        clear_rom();
        rom[0]    = 12'h920;
        rom[9'h20] = 12'h940;
        rom[9'h40] = 12'h811;
        rom[9'h21] = 12'h822;
        start(1'b0, 8'h00);
        step(); chk("R3 exec pc", pc, 1);
        step(); chk("R3 call pc", pc, 9'h20); chk("R3 bubble", nop_slot, 1);
        step(); chk("R3 in sub", pc, 9'h21);
        step(); chk("R3 nested pc", pc, 9'h40);
        step(); chk("R4 w_we", w_we, 1); chk("R4 literal", w_data, 8'h11);
        step(); chk("R4 return inner", pc, 9'h21); chk("R4 bubble", nop_slot, 1);
        chk("R11 bubble quiet", strobes(), 0);
        step(); chk("R4 second literal", w_data, 8'h22);
        step(); chk("R4 return outer", pc, 9'h01);
        step(); chk("R4 after return", pc, 9'h02); chk("R4 slot", nop_slot, 0);
    endtask

    task automatic t_call_page();
        clear_rom();
        rom[0]      = 12'hA00 | 12'h180;
        rom[9'h180] = 12'h933;
        rom[9'h033] = 12'h800;
        start(1'b0, 8'h00);
        repeat (3) step();
        chk("R3 high page exec", pc, 9'h181);
        step(); chk("R3 bit8 cleared", pc, 9'h033);
        step();
        step(); chk("R4 bit8 restored", pc, 9'h181);
        step(); chk("R4 page resume", pc, 9'h182);
    endtask

    task automatic t_overflow();
        clear_rom();
        rom[0]     = 12'h910;
        rom[9'h10] = 12'h920;
        rom[9'h20] = 12'h930;
        rom[9'h30] = 12'h800;
        rom[9'h21] = 12'h800;
        rom[9'h11] = 12'h800;
        start(1'b0, 8'h00);
        repeat (8) step();
        chk("R5 first pop", pc, 9'h21);
        repeat (2) step();
        chk("R5 second pop", pc, 9'h11);
        repeat (2) step();
        chk("R5 oldest lost", pc, 9'h11);
    endtask

    task automatic t_skips();
        logic [11:0] ops [4] = '{12'h2C5, 12'h3C5, 12'h625, 12'h725};
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 2; c++) begin
                clear_rom();
                rom[0] = ops[k];
                start(c[0], 8'h00);
                step(); chk("R6 skip exec", pc, 1);
                step(); chk("R6 skip pc", pc, 2); chk("R6 skip slot", nop_slot, c[0]);
                step(); chk("R6 after skip", nop_slot, 0);
            end
        end
    endtask

    task automatic t_skip_ignored();
        clear_rom();
        rom[0] = FILL_W;
        start(1'b1, 8'h00);
        step();
        step(); chk("R7 cond ignored", nop_slot, 0); chk("R7 pc", pc, 2);
    endtask

    task automatic t_control();
        clear_rom();
        rom[0] = 12'h003; rom[1] = 12'h004; rom[2] = 12'h002;
        rom[3] = 12'h006; rom[4] = 12'h005; rom[5] = 12'h000;
        start(1'b0, 8'h5A);
        step(); chk("R8 sleep", strobes(), 5'b10000);
        step(); chk("R8 wdt clear", strobes(), 5'b01000);
        step(); chk("R9 option", strobes(), 5'b00100); chk("R9 option data", opt_data, 8'h5A);
        step(); chk("R10 direction", strobes(), 5'b00010); chk("R10 dir data", dir_data, 8'h5A);
        step(); chk("R10 other field", strobes(), 5'b00000);
        step(); chk("R12 nop quiet", strobes(), 5'b00000); chk("R12 nop pc", pc, 6);
        step(); chk("R12 nop advance", pc, 7);
    endtask

    task automatic t_bubble_ignored();
        clear_rom();
        rom[0] = 12'hA02;
        rom[1] = 12'hA50;
        start(1'b0, 8'h00);
        step(); step();
        chk("R11 bubble", nop_slot, 1);
        step(); chk("R11 no redirect", pc, 3);
        clear_rom();
        rom[0] = 12'hA10;
        rom[1] = 12'h003;
        start(1'b0, 8'h00);
        step(); step();
        chk("R11 no sleep", sleep_stb, 0);
    endtask

    initial begin
        t_reset();
        t_jump();
        t_call_nest();
        t_call_page();
        t_overflow();
        t_skips();
        t_skip_ignored();
        t_control();
        t_bubble_ignored();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule